// File: doc/BRIEF.md
# Single-Wire Debug Target Bit Transmitter

This block is the transmit engine on the target side of a debug link that runs over one open-drain wire. The host sets the pace of the link: it opens every bit time by pulling the shared wire low. The target then completes that bit in its own clock domain. To send a 0 it holds the wire low for a fixed number of cycles. To send a 1 it leaves the wire released. In both cases it drives the wire high for one cycle as a speedup pulse, so the line rises faster than the pull-up alone would allow.

Software or a command unit loads a byte or a word. The block shifts it out most significant bit first, one bit per host-started bit time. While data remains, `busy` is high. When the last bit has been released, `done` pulses for one cycle. A falling edge that comes while a bit is still in progress has no effect. The pin is controlled through a registered drive-enable and drive-value pair. The wire level is read back through `pin_in`.

Top module: `dbg_bit_tx`

## Requirements
- R1: During reset and in the first cycle after it, `pin_oe`, `pin_out`, `busy` and `done` are all 0.
- R2: When `busy` is 0, a cycle with `load`=1 sets `busy` at the next clock edge. With `load_word`=1 the queued bits are all DATA_W bits of `load_data`. With `load_word`=0 they are the low DATA_W/2 bits. Bits go out most significant first.
- R3: While `busy` is 1, `load` has no effect: the bits already queued go out unchanged.
- R4: A bit starts only on a high-to-low change of `pin_in` while `busy` is 1 and no bit is in progress. `pin_in` passes through a two-flop synchroniser and an edge detector, so a level first sampled low at edge n starts the bit with outputs updated at edge n+2. The cycles that follow are bit cycle 0, 1, 2 and so on.
- R5: A 0 bit drives `pin_oe`=1 with `pin_out`=0 for bit cycles 0 to LOW_CYC-1 (13 by default). This covers the host sample near cycle 10. In cycle LOW_CYC it drives `pin_oe`=1 with `pin_out`=1, then releases the pin.
- R6: A 1 bit keeps `pin_oe`=0 except in bit cycle SPD_AT (4 by default), where `pin_oe`=1 and `pin_out`=1.
- R7: Every bit ends with the pin released in bit cycle LOW_CYC+1. Falling edges on `pin_in` before that point are ignored. The next bit can start only after the release.
- R8: When the last bit ends, `busy` falls and `done` is 1 for exactly that one cycle.
- R9: `pin_out` is 1 only while `pin_oe` is 1. `pin_oe` is 0 whenever `busy` is 0, and edges on `pin_in` have no effect then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Load request, accepted only when idle |
| load_word | input | 1 | 1: send DATA_W bits, 0: send low DATA_W/2 bits |
| load_data | input | DATA_W | Data to transmit, MSB first |
| pin_in | input | 1 | Sampled level of the debug wire |
| pin_oe | output | 1 | Drive enable for the wire (registered) |
| pin_out | output | 1 | Drive value when enabled (registered) |
| busy | output | 1 | Data still queued or a bit in progress |
| done | output | 1 | One-cycle pulse after the final bit's release |

## Verification
The assertions assume that `load` is only meaningful while idle. They also assume that a host low on `pin_in` lasts at least two target cycles, so the synchroniser sees it, and that `pin_in` otherwise follows the pin drive through a pull-up. The stimulus changes `load` and the host drive just after a rising edge. It holds each host low for two cycles and lets the wire idle high between bit times. It also places some host edges inside a running bit and some while the block is idle. In those cases the ignore rules, not the timing, decide the outputs.

// File: rtl/dbg_bit_tx.sv
module dbg_bit_tx #(
  parameter int DATA_W  = 16,
  parameter int LOW_CYC = 13,
  parameter int SPD_AT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_word,
  input  logic [DATA_W-1:0] load_data,
  input  logic              pin_in,
  output logic              pin_oe,
  output logic              pin_out,
  output logic              busy,
  output logic              done
);
  localparam int HALF = DATA_W / 2;
  localparam int CW   = $clog2(LOW_CYC + 2);
  localparam int LW   = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] LAST = CW'(LOW_CYC + 1);

  logic s1, s2, s3;
  logic in_bit;
  logic [CW-1:0] phase;
  logic [DATA_W-1:0] sh;
  logic [LW-1:0] left;
  logic nxt_oe, nxt_out;
  logic [CW-1:0] ph_sel;

  wire fall = s3 & ~s2;
  wire cur  = sh[DATA_W-1];

  assign ph_sel = in_bit ? phase : '0;

  always_comb begin
    nxt_oe  = 1'b0;
    nxt_out = 1'b0;
    if (!cur) begin
      if (ph_sel < CW'(LOW_CYC)) begin
        nxt_oe = 1'b1;
      end else if (ph_sel == CW'(LOW_CYC)) begin
        nxt_oe  = 1'b1;
        nxt_out = 1'b1;
      end
    end else if (ph_sel == CW'(SPD_AT)) begin
      nxt_oe  = 1'b1;
      nxt_out = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
      in_bit <= 1'b0; phase <= '0; sh <= '0; left <= '0;
      pin_oe <= 1'b0; pin_out <= 1'b0; busy <= 1'b0; done <= 1'b0;
    end else begin
      s1 <= pin_in; s2 <= s1; s3 <= s2;
      done <= 1'b0;
      if (!busy) begin
        pin_oe  <= 1'b0;
        pin_out <= 1'b0;
        if (load) begin
          busy <= 1'b1;
          sh   <= load_word ? load_data : {load_data[HALF-1:0], {(DATA_W-HALF){1'b0}}};
          left <= load_word ? LW'(DATA_W) : LW'(HALF);
        end
      end else if (!in_bit) begin
        if (fall) begin
          in_bit  <= 1'b1;
          phase   <= CW'(1);
          pin_oe  <= nxt_oe;
          pin_out <= nxt_out;
        end
      end else begin
        pin_oe  <= nxt_oe;
        pin_out <= nxt_out;
        if (phase == LAST) begin
          in_bit <= 1'b0;
          sh     <= sh << 1;
          left   <= left - LW'(1);
          if (left == LW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          phase <= phase + CW'(1);
        end
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R2
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (!busy && load) |=> busy);
  // R5
  speedup_once_chk: assert property (@(posedge clk) disable iff (!rst_n) (pin_oe && pin_out) |=> !pin_oe);
  // R9
  out_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n) pin_out |-> pin_oe);
  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !$past(busy)) |-> !pin_oe);
endmodule

// File: tb/sim_dbg_bit_tx.sv
module sim_dbg_bit_tx;
  localparam int PERIOD = 10;
  localparam int DW = 16, LOWC = 13, SPD = 4;

  logic clk = 0, rst_n = 0, load = 0, load_word = 0, host_low = 0;
  logic [DW-1:0] load_data = '0;
  logic pin_oe, pin_out, busy, done;
  wire pin_in = host_low ? 1'b0 : (pin_oe ? pin_out : 1'b1);

  int compared = 0, mismatched = 0;
  bit finished = 0;

  dbg_bit_tx #(.DATA_W(DW), .LOW_CYC(LOWC), .SPD_AT(SPD)) u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .load_word(load_word), .load_data(load_data),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .busy(busy), .done(done));

  always #(PERIOD/2) clk = ~clk;

  int hist[4];
  bit q[$];
  bit m_busy = 0, e_oe = 0, e_out = 0, e_busy = 0, e_done = 0, cbit = 0;
  int m_ph = -1;

  task automatic chk(string tag, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R4 R5 R6 R7 R9 pin_oe", pin_oe, e_oe);
      chk("R5 R6 R9 pin_out", pin_out, e_out);
      chk("R2 R3 R8 busy", busy, e_busy);
      chk("R8 done", done, e_done);
      for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = pin_in;
      e_done = 0;
      if (!m_busy) begin
        e_oe = 0; e_out = 0;
        if (load) begin
          q.delete();
          for (int i = (load_word ? DW : DW/2) - 1; i >= 0; i--) q.push_back(load_data[i]);
          m_busy = 1; e_busy = 1;
        end
      end else begin
        int k;
        k = -1;
        if (m_ph < 0) begin
          if (hist[2] == 0 && hist[3] == 1) begin k = 0; cbit = q[0]; end
        end else k = m_ph;
        if (k >= 0) begin
          e_oe = 0; e_out = 0;
          if (!cbit && k < LOWC) e_oe = 1;
          else if ((!cbit && k == LOWC) || (cbit && k == SPD)) begin e_oe = 1; e_out = 1; end
          if (k == LOWC + 1) begin
            void'(q.pop_front());
            m_ph = -1;
            if (q.size() == 0) begin m_busy = 0; e_busy = 0; e_done = 1; end
          end else m_ph = k + 1;
        end
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic host_edge(int wait_after);
    host_low = 1; cyc(2); host_low = 0; cyc(wait_after);
  endtask

  task automatic do_load(logic w, logic [DW-1:0] d);
    load = 1; load_word = w; load_data = d; cyc(1); load = 0;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) hist[i] = 1;
    cyc(3);
    chk("R1 reset pin_oe", pin_oe, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset pin_out", pin_out, 0);
    @(posedge clk); #1;
    host_edge(20);
    do_load(0, 16'h3CA5);
    cyc(2);
    for (int b = 0; b < 8; b++) host_edge(18 + b);
    cyc(5);
    do_load(1, 16'h8001);
    cyc(3);
    do_load(1, 16'hFFFF);
    for (int b = 0; b < 16; b++) begin
      if (b == 3 || b == 9) begin
        host_edge(6); host_edge(16);
      end else host_edge(17);
    end
    cyc(5);
    do_load(0, 16'h00F0);
    host_edge(17);
    do_load(1, 16'h0000);
    for (int b = 0; b < 7; b++) host_edge(17);
    cyc(10);
    do_load(1, 16'h6B2D);
    for (int b = 0; b < 16; b++) host_edge(16);
    cyc(10);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule